// File: doc/BRIEF.md
# Interrupt Raw Status Register Bank

This block keeps the raw, sticky interrupt event flags of a two-wire serial bus controller. The bus engine hands it single-cycle event pulses: a match on the primary own address, a match on any of the alternate own addresses, a general call (all-zero 8-bit address), a stop condition, a repeated start, an access error and a start-triggered wake. Each pulse sets its flag, and the flag stays set until software clears it by writing a one to its bit.

The address-match flag has an extra rule. While its interrupt enable is low, a repeated start or a stop clears it on its own, so a polling host never sees a stale match. While its enable is high, only a write-one clears it. The block also takes the enable mask from outside. It drives a single registered interrupt request, formed from the flags that are both set and enabled. A read always returns the raw flags, whatever the enable mask holds.

Top module: `irqraw_bank`

## Requirements
- R1: While reset is low and on the first cycle after it, every flag reads 0 and `irq_out` is 0.
- R2: A write with `wr_en`=1 clears every flag whose `wr_data` bit is 1, and it leaves every flag whose `wr_data` bit is 0 unchanged.
- R3: The address-match flag at bit 9 sets in the cycle after `ev_own_match`, any bit of `ev_alt_match`, or `ev_gcall` is 1.
- R4: When `irq_en[9]` is 0, a pulse on `ev_stop` or `ev_rstart` clears the address-match flag in the next cycle.
- R5: When `irq_en[9]` is 1, stop and repeated start leave the address-match flag set, and only a write-one clears it.
- R6: The bus-free flag at bit 8 sets in the cycle after an `ev_stop` pulse.
- R7: The access-error flag at bit 7 sets after `ev_acc_err`, and the start-wake flag at bit 6 sets after `ev_wake`.
- R8: If a set event and a clear, whether a write-one or the automatic clear, reach the same flag in the same cycle, the flag ends up set.
- R9: `irq_out` equals the OR over all bits of (flag AND `irq_en`) as it stood one cycle earlier. It is 1 only for enabled flags.
- R10: `rd_data` shows the raw flags regardless of `irq_en`. Bits other than 6, 7, 8 and 9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_own_match | input | 1 | Pulse: primary own address matched |
| ev_alt_match | input | N_ALT | Pulses: alternate own address matched, one bit per alternate |
| ev_gcall | input | 1 | Pulse: all-zero general call address seen |
| ev_stop | input | 1 | Pulse: stop condition detected |
| ev_rstart | input | 1 | Pulse: repeated start detected |
| ev_acc_err | input | 1 | Pulse: data register access error |
| ev_wake | input | 1 | Pulse: start condition woke the block from idle |
| irq_en | input | REG_W | Per-bit interrupt enable mask |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write-one-to-clear data |
| rd_data | output | REG_W | Raw flag read value |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
The assertions assume that each event input is a level sampled once per clock edge, so one high cycle is one event. They also assume that `irq_en` and the write port are stable around the edge. The bench drives every input on the falling edge and holds it through the next rising edge. Random stimulus makes a separate per-cycle draw for each event and for each write. This mix produces overlaps such as a stop with a match and a write-one together with a set. Directed cases cover each auto-clear and enable combination on purpose.

// File: rtl/irqraw_pkg.sv
package irqraw_pkg;
   localparam int BIT_WAKE   = 6;
   localparam int BIT_AERR   = 7;
   localparam int BIT_BFREE  = 8;
   localparam int BIT_AMATCH = 9;
   localparam int MIN_REG_W  = BIT_AMATCH + 1;

   function automatic bit is_flag_bit(input int idx);
      return (idx == BIT_WAKE) || (idx == BIT_AERR) ||
             (idx == BIT_BFREE) || (idx == BIT_AMATCH);
   endfunction
endpackage

// File: rtl/irqraw_event_decode.sv
module irqraw_event_decode #(
   parameter int REG_W = 16,
   parameter int N_ALT = 3
) (
   input  logic             ev_own_match,
   input  logic [N_ALT-1:0] ev_alt_match,
   input  logic             ev_gcall,
   input  logic             ev_stop,
   input  logic             ev_rstart,
   input  logic             ev_acc_err,
   input  logic             ev_wake,
   input  logic             amatch_en,
   output logic [REG_W-1:0] set_vec,
   output logic [REG_W-1:0] aclr_vec
);
   import irqraw_pkg::*;

   logic addr_hit;
   logic frame_edge;

   assign addr_hit   = ev_own_match | (|ev_alt_match) | ev_gcall;
   assign frame_edge = ev_stop | ev_rstart;

   always_comb begin
      set_vec  = '0;
      aclr_vec = '0;
      set_vec[BIT_AMATCH] = addr_hit;
      set_vec[BIT_BFREE]  = ev_stop;
      set_vec[BIT_AERR]   = ev_acc_err;
      set_vec[BIT_WAKE]   = ev_wake;
      aclr_vec[BIT_AMATCH] = frame_edge & ~amatch_en;
   end
endmodule

// File: rtl/irqraw_flag_cell.sv
module irqraw_flag_cell #(
   parameter bit HAS_AUTO = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wclr_i,
   input  logic aclr_i,
   output logic q_o
);
   logic clr_any;

   generate
      if (HAS_AUTO) begin : g_auto
         assign clr_any = wclr_i | aclr_i;
      end else begin : g_plain
         logic unused_aclr;
         assign unused_aclr = aclr_i;
         assign clr_any = wclr_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       q_o <= 1'b0;
      else if (set_i)   q_o <= 1'b1;
      else if (clr_any) q_o <= 1'b0;
   end
endmodule

// File: rtl/irqraw_req_gen.sv
module irqraw_req_gen #(
   parameter int REG_W   = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] flags,
   input  logic [REG_W-1:0] enables,
   output logic             req_o
);
   logic req_comb;
   assign req_comb = |(flags & enables);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) req_o <= 1'b0;
            else        req_o <= req_comb;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign req_o = req_comb;
      end
   endgenerate
endmodule

// File: rtl/irqraw_bank.sv
module irqraw_bank #(
   parameter int REG_W   = 16,
   parameter int N_ALT   = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_own_match,
   input  logic [N_ALT-1:0] ev_alt_match,
   input  logic             ev_gcall,
   input  logic             ev_stop,
   input  logic             ev_rstart,
   input  logic             ev_acc_err,
   input  logic             ev_wake,
   input  logic [REG_W-1:0] irq_en,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             irq_out
);
   import irqraw_pkg::*;

   generate
      if (REG_W < MIN_REG_W) begin : g_bad_width
         $error("irqraw_bank: REG_W too small for fixed flag positions");
      end
      if (N_ALT < 1) begin : g_bad_alt
         $error("irqraw_bank: N_ALT must be at least 1");
      end
   endgenerate

   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] aclr_vec;
   logic [REG_W-1:0] wclr_vec;
   logic [REG_W-1:0] flags;

   assign wclr_vec = wr_en ? wr_data : '0;

   irqraw_event_decode #(.REG_W(REG_W), .N_ALT(N_ALT)) dec_i (
      .ev_own_match (ev_own_match),
      .ev_alt_match (ev_alt_match),
      .ev_gcall     (ev_gcall),
      .ev_stop      (ev_stop),
      .ev_rstart    (ev_rstart),
      .ev_acc_err   (ev_acc_err),
      .ev_wake      (ev_wake),
      .amatch_en    (irq_en[BIT_AMATCH]),
      .set_vec      (set_vec),
      .aclr_vec     (aclr_vec)
   );

   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_bit
         if (is_flag_bit(b)) begin : g_flag
            irqraw_flag_cell #(.HAS_AUTO(b == BIT_AMATCH)) cell_i (
               .clk    (clk),
               .rst_n  (rst_n),
               .set_i  (set_vec[b]),
               .wclr_i (wclr_vec[b]),
               .aclr_i (aclr_vec[b]),
               .q_o    (flags[b])
            );
         end else begin : g_none
            logic unused_b;
            assign unused_b = set_vec[b] ^ aclr_vec[b] ^ wclr_vec[b];
            assign flags[b] = 1'b0;
         end
      end
   endgenerate

   assign rd_data = flags;

   irqraw_req_gen #(.REG_W(REG_W), .OUT_REG(OUT_REG)) req_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (flags),
      .enables (irq_en),
      .req_o   (irq_out)
   );
endmodule

// File: rtl/irqraw_bank_chk.sv
module irqraw_bank_chk #(
   parameter int REG_W   = 16,
   parameter int N_ALT   = 3,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_own_match,
   input logic [N_ALT-1:0] ev_alt_match,
   input logic             ev_gcall,
   input logic             ev_stop,
   input logic             ev_rstart,
   input logic             ev_acc_err,
   input logic             ev_wake,
   input logic [REG_W-1:0] irq_en,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             irq_out
);
   import irqraw_pkg::*;

   logic any_match;
   logic [REG_W-1:0] unused_mask;
   assign any_match = ev_own_match | (|ev_alt_match) | ev_gcall;

   always_comb begin
      unused_mask = '1;
      unused_mask[BIT_WAKE]   = 1'b0;
      unused_mask[BIT_AERR]   = 1'b0;
      unused_mask[BIT_BFREE]  = 1'b0;
      unused_mask[BIT_AMATCH] = 1'b0;
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_data == '0 && !irq_out));

   assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_BFREE] && !ev_stop) |=> !rd_data[BIT_BFREE]);

   assert_write_zero_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[BIT_AERR] && !(wr_en && wr_data[BIT_AERR])) |=> rd_data[BIT_AERR]);

   assert_amatch_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      any_match |=> rd_data[BIT_AMATCH]);

   assert_auto_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_stop || ev_rstart) && !irq_en[BIT_AMATCH] && !any_match) |=> !rd_data[BIT_AMATCH]);

   assert_enabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en[BIT_AMATCH] && rd_data[BIT_AMATCH] && !(wr_en && wr_data[BIT_AMATCH]))
      |=> rd_data[BIT_AMATCH]);

   assert_bus_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> rd_data[BIT_BFREE]);

   assert_aerr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_acc_err |=> rd_data[BIT_AERR]);

   assert_wake_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wake |=> rd_data[BIT_WAKE]);

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wake && wr_en && wr_data[BIT_WAKE]) |=> rd_data[BIT_WAKE]);

   generate
      if (OUT_REG) begin : g_irq_chk
         assert_irq_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (|(rd_data & irq_en)) |=> irq_out);
         assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(rd_data & irq_en)) |=> !irq_out);
      end
   endgenerate

   always_comb begin
      if (rst_n) begin
         assert_unused_zero_R10: assert ((rd_data & unused_mask) == '0);
      end
   end
endmodule

bind irqraw_bank irqraw_bank_chk #(.REG_W(REG_W), .N_ALT(N_ALT), .OUT_REG(OUT_REG)) chk_i (
   .clk(clk), .rst_n(rst_n), .ev_own_match(ev_own_match), .ev_alt_match(ev_alt_match),
   .ev_gcall(ev_gcall), .ev_stop(ev_stop), .ev_rstart(ev_rstart), .ev_acc_err(ev_acc_err),
   .ev_wake(ev_wake), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .irq_out(irq_out)
);

// File: tb/irqraw_bank_tb_top.sv
`timescale 1ns/1ps
module irqraw_bank_tb_top;
   localparam int REG_W = 16;
   localparam int N_ALT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_own_match = 1'b0, ev_gcall = 1'b0, ev_stop = 1'b0, ev_rstart = 1'b0;
   logic ev_acc_err = 1'b0, ev_wake = 1'b0, wr_en = 1'b0;
   logic [N_ALT-1:0] ev_alt_match = '0;
   logic [REG_W-1:0] irq_en = '0, wr_data = '0;
   logic [REG_W-1:0] rd_data;
   logic irq_out;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [REG_W-1:0] m_flags = '0;
   logic m_irq = 1'b0;

   always #10 clk = ~clk;

   irqraw_bank #(.REG_W(REG_W), .N_ALT(N_ALT), .OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .ev_own_match(ev_own_match), .ev_alt_match(ev_alt_match),
      .ev_gcall(ev_gcall), .ev_stop(ev_stop), .ev_rstart(ev_rstart), .ev_acc_err(ev_acc_err),
      .ev_wake(ev_wake), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq_out(irq_out)
   );

   // Expected next flags, from R2..R8: flags at bits 6,7,8,9 only.
   function automatic logic [REG_W-1:0] next_flags(
      input logic [REG_W-1:0] cur, input logic own, input logic [N_ALT-1:0] alt,
      input logic gc, input logic stp, input logic rs, input logic ae, input logic wk,
      input logic [REG_W-1:0] en, input logic we, input logic [REG_W-1:0] wd);
      logic [REG_W-1:0] nxt, setv, clrv;
      setv = '0;
      setv[9] = own | (|alt) | gc;
      setv[8] = stp;
      setv[7] = ae;
      setv[6] = wk;
      clrv = we ? wd : '0;
      clrv[9] = clrv[9] | ((stp | rs) & ~en[9]);
      nxt = (cur & ~clrv) | setv;
      return nxt & 16'h03C0;
   endfunction

   task automatic check(input bit ok, input string req, input logic [REG_W-1:0] act,
                        input logic [REG_W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input string req, input logic own, input logic [N_ALT-1:0] alt,
                       input logic gc, input logic stp, input logic rs, input logic ae,
                       input logic wk, input logic [REG_W-1:0] en, input logic we,
                       input logic [REG_W-1:0] wd);
      ev_own_match = own; ev_alt_match = alt; ev_gcall = gc; ev_stop = stp;
      ev_rstart = rs; ev_acc_err = ae; ev_wake = wk; irq_en = en; wr_en = we; wr_data = wd;
      m_irq = |(m_flags & en);
      m_flags = next_flags(m_flags, own, alt, gc, stp, rs, ae, wk, en, we, wd);
      @(posedge clk);
      @(negedge clk);
      check(rd_data == m_flags, req, rd_data, m_flags);
      check(irq_out == m_irq, {req, "/R9 irq"}, {15'd0, irq_out}, {15'd0, m_irq});
      ev_own_match = 0; ev_alt_match = '0; ev_gcall = 0; ev_stop = 0;
      ev_rstart = 0; ev_acc_err = 0; ev_wake = 0; wr_en = 0;
   endtask

   initial begin
      #3000000;
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check(rd_data == '0, "R1 reset flags", rd_data, '0);
      check(irq_out == 1'b0, "R1 reset irq", {15'd0, irq_out}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rd_data == '0 && irq_out == 0, "R1 after release", rd_data, '0);

      // R3 own match, then R4/R6 stop with enable low
      step("R3 own", 1, '0, 0, 0, 0, 0, 0, '0, 0, '0);
      check(rd_data == 16'h0200, "R3 own value", rd_data, 16'h0200);
      step("R4 stop", 0, '0, 0, 1, 0, 0, 0, '0, 0, '0);
      check(rd_data == 16'h0100, "R4 R6 stop value", rd_data, 16'h0100);
      // R2 write zero keeps, write one clears
      step("R2 w0", 0, '0, 0, 0, 0, 0, 0, '0, 1, 16'hFEFF);
      check(rd_data == 16'h0100, "R2 write0 keeps", rd_data, 16'h0100);
      step("R2 w1", 0, '0, 0, 0, 0, 0, 0, '0, 1, 16'h0100);
      check(rd_data == 16'h0000, "R2 write1 clears", rd_data, 16'h0000);
      // R3 alternate address, R4 repeated start clear
      step("R3 alt", 0, 3'b100, 0, 0, 0, 0, 0, '0, 0, '0);
      check(rd_data == 16'h0200, "R3 alt value", rd_data, 16'h0200);
      step("R4 rstart", 0, '0, 0, 0, 1, 0, 0, '0, 0, '0);
      check(rd_data == 16'h0000, "R4 rstart clear", rd_data, 16'h0000);
      // R5 enable high: general call then repeated start keeps the flag
      step("R3 gcall", 0, '0, 1, 0, 0, 0, 0, 16'h0200, 0, '0);
      step("R5 rstart", 0, '0, 0, 0, 1, 0, 0, 16'h0200, 0, '0);
      check(rd_data == 16'h0200, "R5 held", rd_data, 16'h0200);
      check(irq_out == 1'b1, "R9 enabled irq", {15'd0, irq_out}, 16'h0001);
      step("R5 w1", 0, '0, 0, 0, 0, 0, 0, 16'h0200, 1, 16'h0200);
      check(rd_data == 16'h0000 && irq_out == 1'b1, "R9 lag", {15'd0, irq_out}, 16'h0001);
      step("R9 idle", 0, '0, 0, 0, 0, 0, 0, 16'h0200, 0, '0);
      check(irq_out == 1'b0, "R9 drops", {15'd0, irq_out}, '0);
      // R7 and R10: disabled flags still read raw, no irq
      step("R7 set", 0, '0, 0, 0, 0, 1, 1, '0, 0, '0);
      check(rd_data == 16'h00C0, "R7 value", rd_data, 16'h00C0);
      step("R10 raw", 0, '0, 0, 0, 0, 0, 0, '0, 0, '0);
      check(rd_data == 16'h00C0 && irq_out == 0, "R10 raw disabled", rd_data, 16'h00C0);
      // R8 set wins over write-one and over auto clear
      step("R8 w1", 0, '0, 0, 0, 0, 1, 0, '0, 1, 16'h0080);
      check(rd_data == 16'h00C0, "R8 set wins", rd_data, 16'h00C0);
      step("R8 auto", 1, '0, 0, 1, 0, 0, 0, '0, 0, '0);
      check(rd_data[9] == 1'b1, "R8 match with stop", rd_data, 16'h03C0);
      step("R10 clear all", 0, '0, 0, 0, 0, 0, 0, '0, 1, 16'hFFFF);
      check(rd_data == 16'h0000, "R10 unused zero", rd_data, '0);

      // Constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [REG_W-1:0] en_r, wd_r;
         en_r = 16'($urandom) & 16'h03C0;
         wd_r = 16'($urandom);
         step("R2-mix random", ($urandom % 8) == 0, N_ALT'(($urandom % 6) == 0 ? $urandom : 0),
              ($urandom % 10) == 0, ($urandom % 7) == 0, ($urandom % 7) == 0,
              ($urandom % 9) == 0, ($urandom % 9) == 0, en_r, ($urandom % 4) == 0, wd_r);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule